// File: doc/BRIEF.md
# Predictive Interpolating Upsampler

This block connects a signal that is updated once per slow simulation timestep to a processing element that runs at a faster timestep. Holding the slow sample constant for a whole slow step adds error when the signal moves quickly. This block avoids that. At each slow-step boundary it takes a new sample. From the last three samples it extrapolates the value expected at the next slow boundary, using a second-order Adams-Bashforth rule. The rule is built only from adds, subtracts and arithmetic shifts. At every fast step in between, the output moves linearly from the fresh sample toward that prediction.

The rate ratio n does not have to be a power of two. The caller supplies a precomputed reciprocal 1/n as an unsigned fixed-point constant with `FRAC_W` fractional bits. The block multiplies the distance to the prediction by this constant to get the per-fast-step increment. All data values are signed 32-bit two's complement, and every sum clamps at full scale.

Top module: `pred_upsampler`

## Requirements
- R1: After reset, `value_out` is 0 and the sample history (the three stored samples and the sample count) is cleared.
- R2: A cycle with `slow_tick` high loads `sample_in` into `value_out` at that clock edge. This also holds when `fast_tick` is high in the same cycle: the slow tick takes priority.
- R3: Until two samples have been captured since reset, fast ticks leave `value_out` unchanged.
- R4: Let the captured samples be y0 (newest), y1 and y2, with 0 standing in for samples not yet taken. With d = y0 − y1 and e = y1 − y2, the prediction is y0 + ((d + (d>>>1)) − (e>>>1)). Every sum in this formula saturates.
- R5: The per-fast-step increment is floor((prediction − y0) × recip_in / 2^FRAC_W). `recip_in` is unsigned and has FRAC_W = 16 fractional bits, so 65536 stands for 1.
- R6: Each cycle with `fast_tick` high and `slow_tick` low adds the increment to `value_out`. After n fast ticks with recip_in = 65536/n, the output reaches the prediction to within rounding.
- R7: Every addition and subtraction clamps to the range [−2^31, 2^31−1] and never wraps.
- R8: In a cycle with neither tick, `value_out` keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| slow_tick | input | 1 | Slow-step boundary strobe, one cycle long |
| fast_tick | input | 1 | Fast-step strobe, one cycle long |
| sample_in | input | 32 | Signed slow-rate sample |
| recip_in | input | 32 | Unsigned 1/n constant with FRAC_W fractional bits |
| value_out | output | 32 | Signed fast-rate value |

## Verification
The bench focuses on four corner cases.

- Warm-up window: a design that ramps after only one sample would move the output away from the first captured value.
- History after reset: a design that leaves the history dirty would predict from stale slopes.
- Collision of both strobes in one cycle: if the fast tick won, the output would be the old value plus one increment instead of the fresh sample.
- Clamping: a large step is built so that both the prediction and the ramp exceed full scale. A design that wraps instead of saturating would flip the output to a large negative value.

Mixed-sign sequences and a non-power-of-two ratio check the shift-based slope terms and the floor rounding of the increment.

// File: rtl/ups_pkg.sv
package ups_pkg;
  localparam int DW = 32;
  typedef logic signed [DW-1:0] samp_t;
  localparam samp_t SAMP_MAX = {1'b0, {(DW-1){1'b1}}};
  localparam samp_t SAMP_MIN = {1'b1, {(DW-1){1'b0}}};

  function automatic samp_t sat_add(samp_t a, samp_t b);
    logic signed [DW:0] s;
    s = {a[DW-1], a} + {b[DW-1], b};
    if (s[DW] != s[DW-1]) return s[DW] ? SAMP_MIN : SAMP_MAX;
    return s[DW-1:0];
  endfunction

  function automatic samp_t sat_sub(samp_t a, samp_t b);
    logic signed [DW:0] s;
    s = {a[DW-1], a} - {b[DW-1], b};
    if (s[DW] != s[DW-1]) return s[DW] ? SAMP_MIN : SAMP_MAX;
    return s[DW-1:0];
  endfunction

  // signed delta times unsigned fraction, floor-shifted, clamped
  function automatic samp_t scale(samp_t d, logic [DW-1:0] r, int frac);
    logic signed [2*DW:0] p;
    p = d * $signed({1'b0, r});
    p = p >>> frac;
    if (p[2*DW:DW-1] != {(DW+2){p[2*DW]}}) return p[2*DW] ? SAMP_MIN : SAMP_MAX;
    return p[DW-1:0];
  endfunction
endpackage

// File: rtl/ups_history.sv
module ups_history
  import ups_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  slow_tick,
  input  samp_t sample_in,
  output samp_t y_new,
  output samp_t y_mid,
  output samp_t y_old,
  output logic  ready
);
  localparam int CNT_W = 2;
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      y_new <= '0;
      y_mid <= '0;
      y_old <= '0;
      cnt   <= '0;
    end else if (slow_tick) begin
      y_new <= sample_in;
      y_mid <= y_new;
      y_old <= y_mid;
      if (cnt != CNT_W'(2)) cnt <= cnt + 1'b1;
    end
  end

  assign ready = (cnt == CNT_W'(2));

  // R1: a capture always leaves a non-empty history
  assert_count_live_R1: assert property (@(posedge clk) disable iff (!rst_n)
    slow_tick |=> cnt != '0);
  // R4: the history shifts by one slot per capture
  assert_shift_R4: assert property (@(posedge clk) disable iff (!rst_n)
    slow_tick |=> y_mid == $past(y_new));
endmodule

// File: rtl/ups_predictor.sv
module ups_predictor
  import ups_pkg::*;
#(
  parameter int FRAC_W = 16
) (
  input  samp_t          y_new,
  input  samp_t          y_mid,
  input  samp_t          y_old,
  input  logic           ready,
  input  logic [DW-1:0]  recip,
  output samp_t          pred,
  output samp_t          step
);
  samp_t slope_now, slope_prev, k1, k2, delta;

  always_comb begin
    slope_now  = sat_sub(y_new, y_mid);
    slope_prev = sat_sub(y_mid, y_old);
    k1         = sat_add(slope_now, slope_now >>> 1);
    k2         = sat_sub(k1, slope_prev >>> 1);
    pred       = sat_add(y_new, k2);
    delta      = sat_sub(pred, y_new);
    step       = ready ? scale(delta, recip, FRAC_W) : '0;
  end
endmodule

// File: rtl/ups_ramp.sv
module ups_ramp
  import ups_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  slow_tick,
  input  logic  fast_tick,
  input  logic  ready,
  input  samp_t sample_in,
  input  samp_t step,
  output samp_t value
);
  logic load_ev, adv_ev;
  assign load_ev = slow_tick;
  assign adv_ev  = fast_tick && !slow_tick;

  always_ff @(posedge clk) begin
    if (!rst_n)       value <= '0;
    else if (load_ev) value <= sample_in;
    else if (adv_ev)  value <= sat_add(value, step);
  end

  assert_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    load_ev |=> value == $past(sample_in));
  assert_warmup_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (adv_ev && !ready) |=> $stable(value));
  assert_no_wrap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (adv_ev && step >= 0) |=> value >= $past(value));
  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!slow_tick && !fast_tick) |=> $stable(value));
endmodule

// File: rtl/pred_upsampler.sv
module pred_upsampler
  import ups_pkg::*;
#(
  parameter int FRAC_W = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          slow_tick,
  input  logic          fast_tick,
  input  logic [31:0]   sample_in,
  input  logic [31:0]   recip_in,
  output logic [31:0]   value_out
);
  samp_t y_new, y_mid, y_old, pred, step, val;
  logic  ready;

  ups_history u_hist (
    .clk(clk), .rst_n(rst_n), .slow_tick(slow_tick),
    .sample_in(samp_t'(sample_in)),
    .y_new(y_new), .y_mid(y_mid), .y_old(y_old), .ready(ready)
  );

  ups_predictor #(.FRAC_W(FRAC_W)) u_pred (
    .y_new(y_new), .y_mid(y_mid), .y_old(y_old), .ready(ready),
    .recip(recip_in), .pred(pred), .step(step)
  );

  ups_ramp u_ramp (
    .clk(clk), .rst_n(rst_n), .slow_tick(slow_tick), .fast_tick(fast_tick),
    .ready(ready), .sample_in(samp_t'(sample_in)), .step(step), .value(val)
  );

  assign value_out = val;

  // R1: right after reset the output is zero
  assert_reset_zero_R1: assert property (@(posedge clk)
    !rst_n |=> value_out == '0);
endmodule

// File: tb/tb_pred_upsampler.sv
`timescale 1ns/1ps
module tb_pred_upsampler;
  logic clk = 0, rst_n = 0, slow_tick = 0, fast_tick = 0;
  logic [31:0] sample_in = '0, recip_in = 32'd16384;
  logic [31:0] value_out;
  int checks = 0, errors = 0;
  bit done = 0;

  pred_upsampler dut (.*);

  always #2.5 clk = ~clk;

  // sample, expected per-step increment with n = 4 (recip 16384)
  localparam int NV = 5;
  localparam int VEC [NV][2] = '{
    '{100, 0}, '{200, 25}, '{400, 62}, '{400, -25}, '{-400, -300}
  };

  task automatic cyc(input bit s, input bit f, input int v);
    slow_tick = s; fast_tick = f; sample_in = v;
    @(negedge clk);
    slow_tick = 0; fast_tick = 0;
  endtask

  task automatic chk(input string req, input int exp);
    checks++;
    if ($signed(value_out) !== exp) begin
      errors++;
      $display("FAIL %s got %0d expected %0d", req, $signed(value_out), exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 0;
    @(negedge clk); @(negedge clk);
    rst_n = 1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    do_reset();
    chk("R1 reset value", 0);
    cyc(0, 1, 0);
    chk("R3 tick with empty history", 0);

    // vector walk: R2 load, R3 warm-up, R4/R5 prediction and step, R6 ramp
    for (int i = 0; i < NV; i++) begin
      cyc(1, 0, VEC[i][0]);
      chk("R2 load", VEC[i][0]);
      for (int k = 1; k <= 4; k++) begin
        cyc(0, 1, 0);
        chk(VEC[i][1] == 0 ? "R3 warm-up hold" : "R6 ramp R4 R5", VEC[i][0] + k * VEC[i][1]);
      end
    end
    cyc(0, 0, 12345);
    chk("R8 idle hold", -1600);

    // R2 priority on collision
    cyc(1, 1, 777);
    chk("R2 slow beats fast", 777);

    // R1 reset mid-run, then non-power-of-two ratio, R5 floor
    do_reset();
    chk("R1 reset mid-run", 0);
    recip_in = 32'd21845;
    cyc(1, 0, 0);
    cyc(0, 1, 0);
    chk("R3 one sample only", 0);
    cyc(1, 0, 300);
    for (int k = 1; k <= 3; k++) cyc(0, 1, 0);
    chk("R5 n=3 floor, R4 zero history", 747);

    // R7 saturation of prediction and ramp
    do_reset();
    recip_in = 32'd65536;
    cyc(1, 0, 0);
    cyc(1, 0, 32'h4000_0000);
    cyc(0, 1, 0);
    chk("R7 ramp reaches full scale", 32'sh7FFF_FFFF);
    cyc(0, 1, 0);
    chk("R7 clamp no wrap", 32'sh7FFF_FFFF);

    // R7 negative full scale
    do_reset();
    cyc(1, 0, 0);
    cyc(1, 0, 32'h8000_0000);
    cyc(0, 1, 0);
    chk("R7 negative clamp", 32'sh8000_0000);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule